// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into characters. The line is first passed through a two-flop synchronizer. A falling edge seen while the receiver is idle opens a candidate start bit. From that edge on, a free-running tick at sixteen times the bit rate paces the receiver. Every bit, including the start bit, is decided by a two-of-three vote over the 7th, 8th and 9th tick of that bit. A start bit that votes high is thrown away as a glitch, and the receiver goes back to watching for the next falling edge. Bit timing is re-anchored on every start edge.

The character format is taken from the configuration inputs when the start edge is seen. The data field is 5 to 9 bits, sent LSB first. An optional even or odd parity bit follows the data. Only the first stop bit is examined. The completed character moves into a one-deep hold stage, and from there into the output buffer. The buffer carries the character together with its frame-error, parity-error and overrun flags. A read strobe empties the buffer. Baud generation and clocked synchronous operation belong to other blocks.

Top module: `uart_rx`

## Requirements
- R1: After reset `rx_valid` is 0, `rx_data` is 0 and `rx_ferr`, `rx_perr` and `rx_ovr` are all 0.
- R2: `rxd` passes through two synchronizing flops. A line that stays high never produces a character.
- R3: A falling edge in idle opens a start bit. If the vote over ticks 7, 8 and 9 of that bit is high, the start is dropped and the receiver waits for the next falling edge without producing a character.
- R4: `cfg_bits` selects 5 to 9 data bits, with values below 5 treated as 5 and values above 9 treated as 9. The data bits arrive LSB first and are presented right-aligned on `rx_data`, with the unused upper bits at 0. Each bit is the majority of ticks 7, 8 and 9, so a disturbance that reaches only one of those samples has no effect.
- R5: The parity field `cfg_parity` is encoded as 2'b01 = even, 2'b10 = odd, and 2'b00 or 2'b11 = none. `rx_perr` is 1 when the received parity bit differs from the XOR of the data bits, with that XOR inverted for odd parity. With no parity, no parity bit is expected and `rx_perr` stays 0.
- R6: `rx_ferr` is 1 when the first stop bit votes 0. A second stop bit is never required: a new start bit may follow the first stop bit directly.
- R7: A character and its flags reach the buffer once its first stop bit has been decided. `rx_valid` stays 1, with `rx_data` unchanged, until `rd_strobe` is pulsed. That pulse clears `rx_valid` and all three flags. A pulse while `rx_valid` is 0 has no effect.
- R8: A character that completes while the buffer is full waits in the hold stage. It enters the buffer on the next read, with `rx_ovr` at 0.
- R9: If the buffer is full, a character is waiting in the hold stage, and a new start bit passes its vote, then `rx_ovr` is set on the buffered character, whose data stays unchanged. The waiting character is discarded, and the frame now arriving is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_bits | input | 4 | Number of data bits (5..9) |
| cfg_parity | input | 2 | Parity mode (01 even, 10 odd, 00/11 none) |
| rd_strobe | input | 1 | One-cycle read of the buffer |
| rx_valid | output | 1 | Buffer holds an unread character |
| rx_data | output | 9 | Received character, right-aligned |
| rx_ferr | output | 1 | Frame error of the buffered character |
| rx_perr | output | 1 | Parity error of the buffered character |
| rx_ovr | output | 1 | A later character was lost while this one was unread |

## Verification
Randomly formatted frames are used to sweep every data width and parity mode, including the alternate no-parity code. Some of these frames carry a flipped parity bit or a zero stop bit, so the data path, the parity check and the framing check are each seen to fail on their own. Directed patterns cover the remaining cases:
- A short low pulse on an idle line and a narrow pulse inside a data bit separate glitch rejection from real edges.
- Frames sent back to back with no second stop bit show that the hold stage and the single-stop rule work.
- Three unread frames in a row separate the overrun case from simple queuing, and show which character survives.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

    localparam int CHAR_W = 9;

    typedef enum logic [1:0] {
        PAR_NONE     = 2'b00,
        PAR_EVEN     = 2'b01,
        PAR_ODD      = 2'b10,
        PAR_NONE_ALT = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              ferr;
        logic              perr;
    } rx_char_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic parity_on(input par_mode_e m);
        return (m == PAR_EVEN) || (m == PAR_ODD);
    endfunction

endpackage

// File: rtl/rx_sync.sv
`timescale 1ns/1ps
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd,
    output logic rxd_s,
    output logic fall
);
    logic [STAGES-1:0] sr;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '1;
            prev <= 1'b1;
        end else begin
            sr   <= {sr[STAGES-2:0], rxd};
            prev <= sr[STAGES-1];
        end
    end

    assign rxd_s = sr[STAGES-1];
    assign fall  = prev & ~rxd_s;
endmodule

// File: rtl/rx_deframer.sv
`timescale 1ns/1ps
module rx_deframer
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd_s,
    input  logic       fall,
    input  logic [3:0] cfg_bits,
    input  logic [1:0] cfg_parity,
    output logic       done,
    output logic       start_ok,
    output rx_char_t   chr
);
    localparam int CW    = $clog2(OSR);
    localparam int BW    = $clog2(CHAR_W + 1);
    localparam int S_MID = OSR / 2;
    localparam int S0    = S_MID - 2;
    localparam int S1    = S_MID - 1;
    localparam int S2    = S_MID;

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bitn;
    logic [BW-1:0]     nb_q;
    par_mode_e         par_q;
    logic              s0, s1;
    logic [CHAR_W-1:0] sh;
    logic              acc;
    logic              par_bit;
    logic              v;

    function automatic logic [BW-1:0] clamp_bits(input logic [3:0] b);
        if (b < 4'd5) return BW'(5);
        if (b > 4'd9) return BW'(9);
        return BW'(b);
    endfunction

    assign v = vote3(s0, s1, rxd_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bitn     <= '0;
            nb_q     <= BW'(8);
            par_q    <= PAR_NONE;
            s0       <= 1'b1;
            s1       <= 1'b1;
            sh       <= '0;
            acc      <= 1'b0;
            par_bit  <= 1'b0;
            done     <= 1'b0;
            start_ok <= 1'b0;
            chr      <= '0;
        end else begin
            done     <= 1'b0;
            start_ok <= 1'b0;
            if (state == ST_IDLE) begin
                if (fall) begin
                    state   <= ST_START;
                    cnt     <= '0;
                    bitn    <= '0;
                    sh      <= '0;
                    acc     <= 1'b0;
                    par_bit <= 1'b0;
                    nb_q    <= clamp_bits(cfg_bits);
                    par_q   <= par_mode_e'(cfg_parity);
                end
            end else if (tick) begin
                cnt <= (cnt == CW'(OSR - 1)) ? '0 : cnt + CW'(1);
                if (cnt == CW'(S0)) s0 <= rxd_s;
                if (cnt == CW'(S1)) s1 <= rxd_s;
                if (cnt == CW'(S2)) begin
                    case (state)
                        ST_START: begin
                            if (v) state    <= ST_IDLE;
                            else   start_ok <= 1'b1;
                        end
                        ST_DATA: begin
                            sh  <= {v, sh[CHAR_W-1:1]};
                            acc <= acc ^ v;
                        end
                        ST_PARITY: par_bit <= v;
                        ST_STOP: begin
                            done      <= 1'b1;
                            chr.data  <= sh >> (CHAR_W - int'(nb_q));
                            chr.ferr  <= ~v;
                            chr.perr  <= parity_on(par_q) &
                                         (par_bit ^ acc ^ (par_q == PAR_ODD));
                            state     <= ST_IDLE;
                        end
                        default: ;
                    endcase
                end
                if (cnt == CW'(OSR - 1)) begin
                    case (state)
                        ST_START: state <= ST_DATA;
                        ST_DATA: begin
                            bitn <= bitn + BW'(1);
                            if (bitn == nb_q - BW'(1))
                                state <= parity_on(par_q) ? ST_PARITY : ST_STOP;
                        end
                        ST_PARITY: state <= ST_STOP;
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/rx_holdbuf.sv
`timescale 1ns/1ps
module rx_holdbuf
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     done,
    input  rx_char_t chr_in,
    input  logic     start_ok,
    input  logic     rd,
    output logic     hold_v,
    output rx_char_t hold_q,
    output logic     hold_ovr,
    output logic     pend_v
);
    rx_char_t pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            pend_v   <= 1'b0;
            hold_q   <= '0;
            hold_v   <= 1'b0;
            hold_ovr <= 1'b0;
        end else begin
            if (done) begin
                pend   <= chr_in;
                pend_v <= 1'b1;
            end
            if (pend_v && (!hold_v || rd)) begin
                hold_q   <= pend;
                hold_v   <= 1'b1;
                hold_ovr <= 1'b0;
                if (!done) pend_v <= 1'b0;
            end else begin
                if (rd && hold_v) begin
                    hold_v      <= 1'b0;
                    hold_q.ferr <= 1'b0;
                    hold_q.perr <= 1'b0;
                    hold_ovr    <= 1'b0;
                end
                if (start_ok && pend_v && hold_v && !rd) begin
                    hold_ovr <= 1'b1;
                    if (!done) pend_v <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx.sv
`timescale 1ns/1ps
module uart_rx
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              os_tick,
    input  logic [3:0]        cfg_bits,
    input  logic [1:0]        cfg_parity,
    input  logic              rd_strobe,
    output logic              rx_valid,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_ferr,
    output logic              rx_perr,
    output logic              rx_ovr
);
    logic     rxd_s, fall;
    logic     ch_done, start_ok, pend_valid;
    rx_char_t ch, held;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .rxd   (rxd),
        .rxd_s (rxd_s),
        .fall  (fall)
    );

    rx_deframer #(.OSR(OSR)) u_deframer (
        .clk        (clk),
        .rst        (rst),
        .tick       (os_tick),
        .rxd_s      (rxd_s),
        .fall       (fall),
        .cfg_bits   (cfg_bits),
        .cfg_parity (cfg_parity),
        .done       (ch_done),
        .start_ok   (start_ok),
        .chr        (ch)
    );

    rx_holdbuf u_holdbuf (
        .clk      (clk),
        .rst      (rst),
        .done     (ch_done),
        .chr_in   (ch),
        .start_ok (start_ok),
        .rd       (rd_strobe),
        .hold_v   (rx_valid),
        .hold_q   (held),
        .hold_ovr (rx_ovr),
        .pend_v   (pend_valid)
    );

    assign rx_data = held.data;
    assign rx_ferr = held.ferr;
    assign rx_perr = held.perr;
endmodule

// File: rtl/uart_rx_checker.sv
`timescale 1ns/1ps
module uart_rx_checker (
    input logic       clk,
    input logic       rst,
    input logic       rd_strobe,
    input logic       rx_valid,
    input logic [8:0] rx_data,
    input logic       rx_ferr,
    input logic       rx_perr,
    input logic       rx_ovr,
    input logic       pend_valid,
    input logic       start_ok
);
    AST_EMPTY_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> (!rx_ferr && !rx_perr && !rx_ovr)); // R7

    AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rd_strobe) |=> (rx_valid && $stable(rx_data))); // R7

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rd_strobe && !pend_valid) |=> !rx_valid); // R7

    AST_PEND_MOVES_IN: assert property (@(posedge clk) disable iff (rst)
        (pend_valid && rx_valid && rd_strobe) |=> (rx_valid && !rx_ovr)); // R8

    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ovr) |-> ($past(rx_valid) && $past(pend_valid) && $past(start_ok))); // R9
endmodule

bind uart_rx uart_rx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_strobe  (rd_strobe),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_ferr    (rx_ferr),
    .rx_perr    (rx_perr),
    .rx_ovr     (rx_ovr),
    .pend_valid (pend_valid),
    .start_ok   (start_ok)
);

// File: tb/uart_rx_bench.sv
`timescale 1ns/1ps
module uart_rx_bench;
    localparam int BITCLK = 64;
    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] tdiv = 2'd0;
    logic       os_tick;
    logic [3:0] cfg_bits = 4'd8;
    logic [1:0] cfg_parity = 2'b00;
    logic       rd_strobe = 1'b0;
    logic       rx_valid;
    logic [8:0] rx_data;
    logic       rx_ferr, rx_perr, rx_ovr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign os_tick = (tdiv == 2'd3);

    uart_rx u_uart_rx (
        .clk        (clk),
        .rst        (rst),
        .rxd        (rxd),
        .os_tick    (os_tick),
        .cfg_bits   (cfg_bits),
        .cfg_parity (cfg_parity),
        .rd_strobe  (rd_strobe),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_ferr    (rx_ferr),
        .rx_perr    (rx_perr),
        .rx_ovr     (rx_ovr)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT && !finished) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [8:0] mask_of(input int nb);
        return 9'((1 << nb) - 1);
    endfunction

    function automatic logic exp_par(input logic [8:0] d, input int nb, input int mode);
        logic x;
        x = ^(d & mask_of(nb));
        return (mode == 2) ? ~x : x;
    endfunction

    function automatic bit par_used(input int mode);
        return (mode == 1) || (mode == 2);
    endfunction

    task automatic bit_time(input logic v);
        rxd = v;
        wait_clk(BITCLK);
    endtask

    // glitch_at: index of a data bit that gets a 2-cycle inverted pulse at its centre (-1: none)
    task automatic send_frame(input logic [8:0] d, input int nb, input int mode,
                              input bit flip_par, input logic stop_v, input int nstop,
                              input int glitch_at);
        bit_time(1'b0);
        for (int i = 0; i < nb; i++) begin
            if (i == glitch_at) begin
                rxd = d[i]; wait_clk(31);
                rxd = ~d[i]; wait_clk(2);
                rxd = d[i]; wait_clk(31);
            end else begin
                bit_time(d[i]);
            end
        end
        if (par_used(mode)) bit_time(exp_par(d, nb, mode) ^ flip_par);
        bit_time(stop_v);
        for (int i = 1; i < nstop; i++) bit_time(1'b1);
        rxd = 1'b1;
    endtask

    task automatic expect_char(input string req, input logic [8:0] d, input int nb,
                               input bit fe, input bit pe, input bit ov);
        chk(req, "valid", rx_valid, 1);
        chk(req, "data", rx_data, d & mask_of(nb));
        chk(req, "ferr", rx_ferr, fe);
        chk(req, "perr", rx_perr, pe);
        chk(req, "ovr", rx_ovr, ov);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        wait_clk(1);
        rd_strobe = 1'b0;
        wait_clk(2);
    endtask

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h1A2B3C4D);
        wait_clk(6);
        rst = 1'b0;
        wait_clk(2);

        // R1: reset state
        chk("R1", "valid", rx_valid, 0);
        chk("R1", "data", rx_data, 0);
        chk("R1", "flags", {29'd0, rx_ferr, rx_perr, rx_ovr}, 0);

        // R2: idle line yields nothing
        wait_clk(600);
        chk("R2", "valid on idle line", rx_valid, 0);

        // R7: read while empty has no effect
        do_read();
        chk("R7", "valid after empty read", rx_valid, 0);
        chk("R7", "ovr after empty read", rx_ovr, 0);

        // R3: short low pulse rejected
        rxd = 1'b0; wait_clk(12); rxd = 1'b1;
        wait_clk(300);
        chk("R3", "valid after noise start", rx_valid, 0);
        cfg_bits = 4'd8; cfg_parity = 2'b00;
        send_frame(9'h0A5, 8, 0, 0, 1'b1, 1, -1);
        wait_clk(20);
        expect_char("R3", 9'h0A5, 8, 0, 0, 0);
        do_read();

        // R4: single-sample glitch inside a data bit
        send_frame(9'h0FF, 8, 0, 0, 1'b1, 1, 3);
        wait_clk(20);
        expect_char("R4", 9'h0FF, 8, 0, 0, 0);
        do_read();

        // R4: out-of-range widths clamp
        cfg_bits = 4'd2;
        send_frame(9'h1F, 5, 0, 0, 1'b1, 1, -1);
        wait_clk(20);
        expect_char("R4", 9'h1F, 5, 0, 0, 0);
        do_read();
        cfg_bits = 4'd15;
        send_frame(9'h1C3, 9, 0, 0, 1'b1, 1, -1);
        wait_clk(20);
        expect_char("R4", 9'h1C3, 9, 0, 0, 0);
        do_read();

        // R5: alternate no-parity code expects no parity bit
        cfg_bits = 4'd7; cfg_parity = 2'b11;
        send_frame(9'h055, 7, 3, 0, 1'b1, 1, -1);
        wait_clk(20);
        expect_char("R5", 9'h055, 7, 0, 0, 0);
        do_read();

        // R6 / R8: back-to-back frames without second stop, no read between
        cfg_bits = 4'd8; cfg_parity = 2'b01;
        send_frame(9'h03C, 8, 1, 0, 1'b1, 1, -1);
        send_frame(9'h0C7, 8, 1, 0, 1'b1, 1, -1);
        wait_clk(20);
        expect_char("R6", 9'h03C, 8, 0, 0, 0);
        do_read();
        expect_char("R8", 9'h0C7, 8, 0, 0, 0);
        do_read();
        chk("R7", "valid after read", rx_valid, 0);

        // R9: overrun
        cfg_parity = 2'b00;
        send_frame(9'h011, 8, 0, 0, 1'b1, 1, -1);
        wait_clk(10);
        send_frame(9'h022, 8, 0, 0, 1'b1, 1, -1);
        wait_clk(10);
        expect_char("R8", 9'h011, 8, 0, 0, 0);
        send_frame(9'h033, 8, 0, 0, 1'b1, 1, -1);
        wait_clk(20);
        expect_char("R9", 9'h011, 8, 0, 0, 1);
        do_read();
        expect_char("R9", 9'h033, 8, 0, 0, 0);
        do_read();
        chk("R9", "valid after final read", rx_valid, 0);

        // Random frames: R4 R5 R6 R7
        for (int n = 0; n < 26; n++) begin
            int nb, mode, nstop;
            bit flip, pe;
            logic stopv;
            logic [8:0] d;
            nb    = 5 + int'($urandom % 5);
            mode  = int'($urandom % 4);
            nstop = 1 + int'($urandom % 2);
            d     = 9'($urandom) & mask_of(nb);
            flip  = par_used(mode) && ($urandom % 4 == 0);
            stopv = ($urandom % 6 != 0);
            pe    = flip;
            cfg_bits = 4'(nb); cfg_parity = 2'(mode);
            wait_clk(3);
            send_frame(d, nb, mode, flip, stopv, nstop, -1);
            wait_clk(20);
            expect_char("R5", d, nb, !stopv, pe, 0);
            do_read();
            chk("R7", "valid cleared by read", rx_valid, 0);
            chk("R7", "ferr cleared by read", rx_ferr, 0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule